// File: doc/BRIEF.md
# Reset-Gated Memory Chip-Select Guard

This block sits on the active-low chip-select path between a processor and an external static RAM. In normal running it hands the processor's chip enable straight through to the memory's select pin. When the system reset condition is raised, it closes the path so that the memory sees an idle select and cannot be written with corrupt data while the supply is failing. The path does not open again until a recovery window has elapsed after the reset condition clears.

The closing point depends on what the processor is doing. If the enable is idle when reset arrives, the path shuts in that same cycle. If a cycle is in flight, the path stays open for a short grace interval so the write can complete. It shuts early if the enable returns idle first. A parameter selects a variant with a shorter grace interval and a recovery window half as long. A power-up indication from the reset sequencer initialises the block and starts a full recovery window. An acceptance flag reports whether the enable is currently being passed on.

Top module: `mem_cs_guard`

## Requirements
- R1: While the path is open and no reset condition is present, `cs_out_n` equals `ce_in_n` in the same cycle, for any sequence of enable values.
- R2: While `pwr_up` is 1, `cs_out_n` is 1 and `e_accept` is 0. The path then stays closed until REC_CYC clock edges have followed the last edge that sampled `pwr_up` high.
- R3: If `rst_act` is 1 while the path is open and `ce_in_n` is 1, the path closes in that same cycle (`e_accept` 0, `cs_out_n` 1).
- R4: If `rst_act` is sampled 1 on an edge while the path is open and `ce_in_n` is 0, the path stays open for the next GRACE_LONG_CYC clock edges and closes after the edge that follows them.
- R5: If `ce_in_n` goes to 1 during the grace interval, the path closes in that cycle and stays closed even if the enable falls again.
- R6: While the path is closed, `cs_out_n` is 1 whatever value `ce_in_n` takes.
- R7: Once `rst_act` is sampled 0, the path stays closed for REC_CYC clock edges and opens on the following edge. A new assertion of `rst_act` during this window closes it again and restarts the full window.
- R8: With SHORT_MODE = 1, the grace interval is GRACE_SHORT_CYC edges and the recovery window is REC_CYC/2 edges.
- R9: `e_accept` is 1 exactly when the path is open. Whenever it is 1, `cs_out_n` equals `ce_in_n`.
- R10: On the cycle the path reopens, `cs_out_n` takes the value `ce_in_n` has at that time, with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| pwr_up | input | 1 | Power-up indication from the reset sequencer, active high; initialises the block |
| rst_act | input | 1 | System reset condition, active high |
| ce_in_n | input | 1 | Processor chip enable, active low |
| cs_out_n | output | 1 | Memory chip select, active low |
| e_accept | output | 1 | 1 while the enable is being passed through |

## Verification
The bench targets the cycle counts of the grace interval and the recovery window. A counter that is one edge off would let a select through one cycle early, or hold it one cycle too long, at the exact boundary the bench samples. It also raises reset with the enable idle. A design that decided only on a clock edge would let a select slip through in that cycle. The enable is released in the middle of the grace interval and then pulled low again. A design that waited out the full interval would pass that second, unwanted select. The bench also re-raises reset during recovery and runs the half-length variant beside the default one. An unrestarted window, or a variant that kept the full window, would show up as an early reopening.

// File: rtl/memcs_pkg.sv
package memcs_pkg;

  typedef enum logic [1:0] {
    GS_PASS  = 2'd0,
    GS_GRACE = 2'd1,
    GS_BLOCK = 2'd2,
    GS_RECOV = 2'd3
  } gate_st_e;

  // grace interval in cycles for the selected mode
  function automatic int unsigned grace_cycles(bit short_mode,
                                               int unsigned long_c,
                                               int unsigned short_c);
    int unsigned r;
    r = short_mode ? short_c : long_c;
    if (r == 0) r = 1;
    return r;
  endfunction

  // recovery window: full length, or half of it in the short mode
  function automatic int unsigned recov_cycles(bit short_mode, int unsigned full_c);
    int unsigned r;
    r = short_mode ? (full_c / 2) : full_c;
    if (r == 0) r = 1;
    return r;
  endfunction

  // counter width able to hold values 0..n
  function automatic int unsigned span_width(int unsigned n);
    int unsigned w;
    w = $clog2(n + 1);
    if (w == 0) w = 1;
    return w;
  endfunction

endpackage

// File: rtl/ce_span_counter.sv
module ce_span_counter #(
  parameter int unsigned LEN = 4,
  parameter int unsigned W   = 3
) (
  input  logic clk,
  input  logic clr,
  input  logic run,
  output logic last
);
  localparam logic [W-1:0] LAST_V = W'(LEN - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (clr)                           cnt_q <= '0;
    else if (run && (cnt_q != LAST_V)) cnt_q <= cnt_q + W'(1);
  end

  assign last = (cnt_q == LAST_V);

  // R4 R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (clr)
    cnt_q <= LAST_V);

endmodule

// File: rtl/ce_gate_fsm.sv
module ce_gate_fsm
  import memcs_pkg::*;
(
  input  logic     clk,
  input  logic     pwr_up,
  input  logic     rst_act,
  input  logic     ce_in_n,
  input  logic     grace_last,
  input  logic     recov_last,
  output gate_st_e state,
  output logic     path_en
);
  gate_st_e st_q, st_d;

  // named events for the checks
  logic hit_idle, hit_busy, grace_abort, grace_expire, recov_done;
  assign hit_idle     = (st_q == GS_PASS)  && rst_act && ce_in_n;
  assign hit_busy     = (st_q == GS_PASS)  && rst_act && !ce_in_n;
  assign grace_abort  = (st_q == GS_GRACE) && ce_in_n;
  assign grace_expire = (st_q == GS_GRACE) && grace_last;
  assign recov_done   = (st_q == GS_RECOV) && !rst_act && recov_last;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      GS_PASS:  if (hit_idle) st_d = GS_BLOCK;
                else if (hit_busy) st_d = GS_GRACE;
      GS_GRACE: if (grace_abort || grace_expire) st_d = GS_BLOCK;
      GS_BLOCK: if (!rst_act) st_d = GS_RECOV;
      GS_RECOV: if (rst_act) st_d = GS_BLOCK;
                else if (recov_done) st_d = GS_PASS;
      default:  st_d = GS_RECOV;
    endcase
  end

  always_ff @(posedge clk) begin
    if (pwr_up) st_q <= GS_RECOV;
    else        st_q <= st_d;
  end

  always_comb begin
    unique case (st_q)
      GS_PASS:  path_en = !(rst_act && ce_in_n);
      GS_GRACE: path_en = !ce_in_n;
      default:  path_en = 1'b0;
    endcase
    if (pwr_up) path_en = 1'b0;
  end

  assign state = st_q;

  // R4
  grace_span_chk: assert property (@(posedge clk) disable iff (pwr_up)
    (st_q == GS_GRACE && !grace_last && !ce_in_n) |=> (st_q == GS_GRACE));

  // R5
  grace_abort_chk: assert property (@(posedge clk) disable iff (pwr_up)
    grace_abort |=> (st_q == GS_BLOCK));

endmodule

// File: rtl/ce_out_stage.sv
module ce_out_stage (
  input  logic ce_in_n,
  input  logic path_en,
  output logic cs_out_n,
  output logic accept
);
  assign cs_out_n = path_en ? ce_in_n : 1'b1;
  assign accept   = path_en;
endmodule

// File: rtl/mem_cs_guard.sv
module mem_cs_guard
  import memcs_pkg::*;
#(
  parameter int unsigned REC_CYC         = 40,
  parameter int unsigned GRACE_LONG_CYC  = 6,
  parameter int unsigned GRACE_SHORT_CYC = 4,
  parameter bit          SHORT_MODE      = 1'b0
) (
  input  logic clk,
  input  logic pwr_up,
  input  logic rst_act,
  input  logic ce_in_n,
  output logic cs_out_n,
  output logic e_accept
);
  localparam int unsigned GRACE_LEN = grace_cycles(SHORT_MODE, GRACE_LONG_CYC, GRACE_SHORT_CYC);
  localparam int unsigned REC_LEN   = recov_cycles(SHORT_MODE, REC_CYC);
  localparam int unsigned GW        = span_width(GRACE_LEN);
  localparam int unsigned RW        = span_width(REC_LEN);

  gate_st_e state;
  logic     path_en;
  logic     grace_last, recov_last;
  logic     grace_clr, recov_clr;

  assign grace_clr = pwr_up || (state != GS_GRACE);
  assign recov_clr = pwr_up || rst_act || (state != GS_RECOV);

  ce_span_counter #(.LEN(GRACE_LEN), .W(GW)) u_grace (
    .clk (clk),
    .clr (grace_clr),
    .run (state == GS_GRACE),
    .last(grace_last)
  );

  ce_span_counter #(.LEN(REC_LEN), .W(RW)) u_recov (
    .clk (clk),
    .clr (recov_clr),
    .run (state == GS_RECOV),
    .last(recov_last)
  );

  ce_gate_fsm u_fsm (
    .clk       (clk),
    .pwr_up    (pwr_up),
    .rst_act   (rst_act),
    .ce_in_n   (ce_in_n),
    .grace_last(grace_last),
    .recov_last(recov_last),
    .state     (state),
    .path_en   (path_en)
  );

  ce_out_stage u_out (
    .ce_in_n (ce_in_n),
    .path_en (path_en),
    .cs_out_n(cs_out_n),
    .accept  (e_accept)
  );

  // R6
  blocked_high_chk: assert property (@(posedge clk) disable iff (pwr_up)
    !e_accept |-> cs_out_n);

  // R9
  accept_follow_chk: assert property (@(posedge clk) disable iff (pwr_up)
    e_accept |-> (cs_out_n == ce_in_n));

  // R3
  idle_block_chk: assert property (@(posedge clk) disable iff (pwr_up)
    (rst_act && ce_in_n) |-> !e_accept);

  // R5
  block_hold_chk: assert property (@(posedge clk) disable iff (pwr_up)
    (!e_accept && rst_act) |=> !e_accept);

  // R7
  reopen_chk: assert property (@(posedge clk) disable iff (pwr_up)
    $rose(e_accept) |-> $past(recov_last));

  // R2
  always_ff @(posedge clk) begin
    if (pwr_up) begin
      pwrup_block_chk: assert (!e_accept && cs_out_n);
    end
  end

endmodule

// File: tb/tb_mem_cs_guard.sv
module tb_mem_cs_guard;
  localparam int REC  = 40;
  localparam int GL   = 6;
  localparam int GS   = 4;
  localparam int RECV = REC / 2;

  logic clk = 1'b0;
  logic pwr_up, rst_act, ce_in_n;
  logic cs_out_n, e_accept, cs_v, acc_v;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mem_cs_guard #(.REC_CYC(REC), .GRACE_LONG_CYC(GL), .GRACE_SHORT_CYC(GS), .SHORT_MODE(1'b0)) dut (
    .clk(clk), .pwr_up(pwr_up), .rst_act(rst_act), .ce_in_n(ce_in_n),
    .cs_out_n(cs_out_n), .e_accept(e_accept));

  mem_cs_guard #(.REC_CYC(REC), .GRACE_LONG_CYC(GL), .GRACE_SHORT_CYC(GS), .SHORT_MODE(1'b1)) dut_v (
    .clk(clk), .pwr_up(pwr_up), .rst_act(rst_act), .ce_in_n(ce_in_n),
    .cs_out_n(cs_v), .e_accept(acc_v));

  // pass-through vectors: {ce_in_n, expected cs_out_n, expected e_accept}
  localparam logic [2:0] VEC [0:9] = '{
    3'b111, 3'b001, 3'b001, 3'b111, 3'b001,
    3'b111, 3'b111, 3'b001, 3'b111, 3'b001
  };

  task automatic edges(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(string req, logic act_c, logic act_a, logic exp_c, logic exp_a);
    checks++;
    if (act_c !== exp_c || act_a !== exp_a) begin
      errors++;
      $display("FAIL %s: cs_out_n=%b e_accept=%b expected cs_out_n=%b e_accept=%b",
               req, act_c, act_a, exp_c, exp_a);
    end
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    pwr_up = 1'b1; rst_act = 1'b0; ce_in_n = 1'b1;
    #1;
    ce_in_n = 1'b0; #1;
    chk("R2 during power-up", cs_out_n, e_accept, 1'b1, 1'b0);
    edges(3);
    chk("R2 held power-up", cs_out_n, e_accept, 1'b1, 1'b0);
    pwr_up = 1'b0;
    // R6: toggling enable during the power-up window has no effect
    for (int i = 0; i < REC - 1; i++) begin
      ce_in_n = i[0];
      edges(1);
      if (i % 8 == 0) chk("R6 ignored in recovery", cs_out_n, e_accept, 1'b1, 1'b0);
    end
    ce_in_n = 1'b0; #1;
    chk("R2 last blocked edge", cs_out_n, e_accept, 1'b1, 1'b0);
    edges(1);
    chk("R10 reopen takes current enable", cs_out_n, e_accept, 1'b0, 1'b1);

    // R1: pass-through table
    for (int k = 0; k < 10; k++) begin
      ce_in_n = VEC[k][2]; #1;
      chk("R1 pass-through", cs_out_n, e_accept, VEC[k][1], VEC[k][0]);
      edges(1);
    end

    // R3 and R6: reset with idle enable
    ce_in_n = 1'b1; rst_act = 1'b1; #1;
    chk("R3 idle enable closes at once", cs_out_n, e_accept, 1'b1, 1'b0);
    edges(1);
    ce_in_n = 1'b0; #1;
    chk("R6 enable ignored while closed", cs_out_n, e_accept, 1'b1, 1'b0);
    edges(5);
    rst_act = 1'b0;
    edges(10);
    rst_act = 1'b1; #1;
    chk("R7 re-raise in recovery", cs_out_n, e_accept, 1'b1, 1'b0);
    edges(1);
    rst_act = 1'b0;
    edges(REC);
    chk("R7 full window after restart", cs_out_n, e_accept, 1'b1, 1'b0);
    edges(1);
    chk("R7 reopen after window", cs_out_n, e_accept, 1'b0, 1'b1);
    chk("R9 accept while open", cs_v, acc_v, 1'b0, 1'b1);

    // R4: reset during an active cycle
    rst_act = 1'b1; #1;
    chk("R4 open at reset", cs_out_n, e_accept, 1'b0, 1'b1);
    edges(GL);
    chk("R4 still open at grace end", cs_out_n, e_accept, 1'b0, 1'b1);
    edges(1);
    chk("R4 closed after grace", cs_out_n, e_accept, 1'b1, 1'b0);
    rst_act = 1'b0;
    edges(REC + 1);
    chk("R7 reopen after grace reset", cs_out_n, e_accept, 1'b0, 1'b1);

    // R5: enable released during grace
    rst_act = 1'b1;
    edges(2);
    chk("R5 in grace", cs_out_n, e_accept, 1'b0, 1'b1);
    ce_in_n = 1'b1; #1;
    chk("R5 release closes", cs_out_n, e_accept, 1'b1, 1'b0);
    edges(1);
    ce_in_n = 1'b0; #1;
    chk("R5 stays closed", cs_out_n, e_accept, 1'b1, 1'b0);
    rst_act = 1'b0;
    edges(REC + 1);
    chk("R10 reopen with low enable", cs_out_n, e_accept, 1'b0, 1'b1);

    // R8: short variant
    pwr_up = 1'b1;
    edges(2);
    pwr_up = 1'b0;
    edges(RECV - 1);
    chk("R8 variant blocked", cs_v, acc_v, 1'b1, 1'b0);
    edges(1);
    chk("R8 variant half window", cs_v, acc_v, 1'b0, 1'b1);
    chk("R8 full mode still blocked", cs_out_n, e_accept, 1'b1, 1'b0);
    edges(REC - RECV);
    chk("R8 full mode reopens", cs_out_n, e_accept, 1'b0, 1'b1);
    rst_act = 1'b1;
    edges(GS);
    chk("R8 variant grace open", cs_v, acc_v, 1'b0, 1'b1);
    edges(1);
    chk("R8 variant grace closed", cs_v, acc_v, 1'b1, 1'b0);
    chk("R4 full mode still in grace", cs_out_n, e_accept, 1'b0, 1'b1);
    rst_act = 1'b0;
    edges(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule